// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O port that sits on a simple memory-mapped register bus. The bus has an address, a write strobe with write data, and a read strobe with read data. The port has one pin for each bit of the register width. For every pin it drives an output value and an output enable toward the pads, and it samples the pad input through a two-flop synchronizer.

Software changes the output levels in three ways. It can load the whole word through the data register. It can raise chosen pins through the set register. It can lower chosen pins through the clear register. A direction register picks which pins are driven. Elaboration-time options change how the bus sees the port:

- which direction value means "output";
- a mirrored pin-to-bit order;
- a byte-reversed bus word for big-endian hosts;
- a read-back mode that returns the output-value register through the set register.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: `WIDTH` must be 8, 16, 32 or 64, and the port has `WIDTH` pins.
  - Registers sit at byte offsets 0, 1, 2 and 3 times `WIDTH/8`, in this order: data, set, clear, direction.
  - A read from any other address, including a misaligned one, returns zero. A write to such an address changes nothing.
  - A read of the clear register returns zero.
- R2: A write to the data register loads the whole output-value word, and `pin_out` shows it after that clock edge. With no write to data, set or clear, the output word holds.
- R3: A write to the set register drives high every pin whose written bit is 1. Pins whose written bit is 0 keep their value.
- R4: A write to the clear register drives low every pin whose written bit is 1. Pins whose written bit is 0 keep their value.
- R5: Direction polarity is chosen by `DIR_IS_INPUT`.
  - With `DIR_IS_INPUT=0`, a direction bit of 1 enables that pin's output.
  - With `DIR_IS_INPUT=1`, a direction bit of 1 makes that pin an input, so its output enable is low.
  - A read of the direction register returns the value last written.
- R6: A read of the data register returns, for each pin, the driven value if the pin is an output. If the pin is an input, it returns the pin input after two synchronizer flops: a change on `pin_in` becomes readable through a read issued two clock edges after the change.
- R7: With `BIT_MIRROR=1`, pin n uses register bit `WIDTH-1-n` in every register, for both reads and writes.
- R8: With `BYTE_SWAP=1`, the bus word is byte-reversed on both writes and reads (byte k maps to byte `WIDTH/8-1-k`). Elaboration rejects this option when `WIDTH` is 64.
- R9: With `SET_READBACK=1`, a read of the set register returns the output-value word. With `SET_READBACK=0`, it returns zero.
- R10: Reset has the following effect:
  - the output-value word is cleared;
  - every pin becomes an input, so every `pin_oe` is 0 (the direction register resets to all zeros, or to all ones when `DIR_IS_INPUT=1`);
  - both synchronizer stages are cleared;
  - `rd_data` is cleared.
- R11: `rd_data` is registered. It takes the addressed value at the clock edge where `rd_en` is high, based on the state before that edge. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pad input levels |
| pin_out | output | WIDTH | Output value per pin |
| pin_oe | output | WIDTH | Output enable per pin |

## Verification
The assertions assume that at most one register is written in any cycle. This always holds here, because there is a single bus address. They also assume that reset is applied before the first write.

The bench issues every access through the one address port. It keeps `wr_en` and `rd_en` free to appear together on any address, including misaligned and out-of-range ones. `pin_in` changes only at falling edges, so the two-flop path sees no race.

Two instances share the same stimulus:
- one with default options;
- one with inverted direction polarity, mirrored bits, byte swapping and set read-back.

This lets the mapping options be checked against the same register writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      GREG_DATA = 2'd0,
      GREG_SET  = 2'd1,
      GREG_CLR  = 2'd2,
      GREG_DIR  = 2'd3
   } gpio_reg_e;

   localparam int GPIO_NUM_REGS = 4;
endpackage

// File: rtl/gpio_lane_xform.sv
// Maps between bus-word order and pin order: optional byte reversal and then
// optional bit mirroring. Both are involutions and commute, so the same
// instance type serves the write path and the read path.
module gpio_lane_xform #(
   parameter int WIDTH  = 32,
   parameter bit MIRROR = 1'b0,
   parameter bit SWAP   = 1'b0
) (
   input  logic [WIDTH-1:0] word_in,
   output logic [WIDTH-1:0] word_out
);
   localparam int NBYTES = WIDTH / 8;

   logic [WIDTH-1:0] swapped;

   generate
      if (SWAP) begin : g_swap
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign swapped[b*8 +: 8] = word_in[(NBYTES-1-b)*8 +: 8];
         end
      end else begin : g_noswap
         assign swapped = word_in;
      end

      if (MIRROR) begin : g_mirror
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign word_out[i] = swapped[WIDTH-1-i];
         end
      end else begin : g_straight
         assign word_out = swapped;
      end
   endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for the asynchronous pad inputs.
module gpio_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
// Output-value and direction state, held in pin order.
module gpio_pin_regs #(
   parameter int WIDTH        = 32,
   parameter bit DIR_IS_INPUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we_data,
   input  logic             we_set,
   input  logic             we_clr,
   input  logic             we_dir,
   input  logic [WIDTH-1:0] wword,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] oe
);
   localparam logic [WIDTH-1:0] DIR_RESET = DIR_IS_INPUT ? '1 : '0;

   logic [WIDTH-1:0] out_d;

   always_comb begin
      out_d = out_q;
      if (we_data)     out_d = wword;
      else begin
         if (we_set)   out_d = out_d | wword;
         if (we_clr)   out_d = out_d & ~wword;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= '0;
         dir_q <= DIR_RESET;
      end else begin
         out_q <= out_d;
         if (we_dir) dir_q <= wword;
      end
   end

   generate
      if (DIR_IS_INPUT) begin : g_pol_in
         assign oe = ~dir_q;
      end else begin : g_pol_out
         assign oe = dir_q;
      end
   endgenerate

   // R2: a data write loads the whole word
   p_load_r2: assert property (@(posedge clk) disable iff (rst)
      we_data |=> out_q == $past(wword));

   // R2: without output writes the word holds
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !(we_data || we_set || we_clr) |=> $stable(out_q));

   // R3: set bits read back high
   p_set_r3: assert property (@(posedge clk) disable iff (rst)
      (we_set && !we_data && !we_clr) |=> ((out_q & $past(wword)) == $past(wword)));

   // R4: cleared bits read back low
   p_clr_r4: assert property (@(posedge clk) disable iff (rst)
      (we_clr && !we_data) |=> ((out_q & $past(wword)) == '0));

   // R10: just out of reset no pin is driven
   p_rst_in_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (oe == '0 && out_q == '0));
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl #(
   parameter int WIDTH        = 32,
   parameter int ADDR_W       = 8,
   parameter bit DIR_IS_INPUT = 1'b0,
   parameter bit BIT_MIRROR   = 1'b0,
   parameter bit BYTE_SWAP    = 1'b0,
   parameter bit SET_READBACK = 1'b0,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic              rd_en,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   import gpio_pkg::*;

   localparam int NBYTES = WIDTH / 8;
   localparam int LB     = (NBYTES > 1) ? $clog2(NBYTES) : 0;

   generate
      if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
         $error("mmio_gpio_ctrl: WIDTH must be 8, 16, 32 or 64");
      end
      if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
         $error("mmio_gpio_ctrl: byte swap is not available for 64-bit width");
      end
      if (ADDR_W < LB + 2) begin : g_bad_addr
         $error("mmio_gpio_ctrl: ADDR_W too small for the register map");
      end
   endgenerate

   // address decode
   logic              aligned;
   logic [ADDR_W-1:0] word_idx;
   logic              mapped;
   gpio_reg_e         sel;

   generate
      if (LB == 0) begin : g_align_byte
         assign aligned = 1'b1;
      end else begin : g_align_word
         assign aligned = (addr[LB-1:0] == '0);
      end
   endgenerate

   assign word_idx = addr >> LB;
   assign mapped   = aligned && (word_idx < ADDR_W'(GPIO_NUM_REGS));
   assign sel      = gpio_reg_e'(word_idx[1:0]);

   // write path: bus order -> pin order
   logic [WIDTH-1:0] wword;

   gpio_lane_xform #(.WIDTH(WIDTH), .MIRROR(BIT_MIRROR), .SWAP(BYTE_SWAP)) u_wr_xform (
      .word_in  (wr_data),
      .word_out (wword)
   );

   logic we_ok;
   assign we_ok = wr_en && mapped;

   logic [WIDTH-1:0] out_q, dir_q, oe;

   gpio_pin_regs #(.WIDTH(WIDTH), .DIR_IS_INPUT(DIR_IS_INPUT)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .we_data (we_ok && sel == GREG_DATA),
      .we_set  (we_ok && sel == GREG_SET),
      .we_clr  (we_ok && sel == GREG_CLR),
      .we_dir  (we_ok && sel == GREG_DIR),
      .wword   (wword),
      .out_q   (out_q),
      .dir_q   (dir_q),
      .oe      (oe)
   );

   logic [WIDTH-1:0] in_sync;

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (pin_in),
      .sync_out (in_sync)
   );

   // read path: select in pin order, then pin order -> bus order
   logic [WIDTH-1:0] level;
   logic [WIDTH-1:0] rsel;
   logic [WIDTH-1:0] rword;

   assign level = (out_q & oe) | (in_sync & ~oe);

   always_comb begin
      rsel = '0;
      if (mapped) begin
         unique case (sel)
            GREG_DATA: rsel = level;
            GREG_SET:  rsel = SET_READBACK ? out_q : '0;
            GREG_CLR:  rsel = '0;
            GREG_DIR:  rsel = dir_q;
         endcase
      end
   end

   gpio_lane_xform #(.WIDTH(WIDTH), .MIRROR(BIT_MIRROR), .SWAP(BYTE_SWAP)) u_rd_xform (
      .word_in  (rsel),
      .word_out (rword)
   );

   always_ff @(posedge clk) begin
      if (rst)        rd_data <= '0;
      else if (rd_en) rd_data <= rword;
   end

   assign pin_out = out_q;
   assign pin_oe  = oe;

   // R11: read data holds while no read is issued
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R1: unmapped reads return zero
   p_unmapped_r1: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !mapped) |=> rd_data == '0);
endmodule

// File: tb/mmio_gpio_ctrl_tb.sv
module mmio_gpio_ctrl_tb;
   localparam int W  = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  rd0, po0, oe0, rd1, po1, oe1;

   int vectors = 0;
   int errors  = 0;

   always #5 clk = ~clk;

   mmio_gpio_ctrl #(.WIDTH(W), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd0), .pin_in(pin_in), .pin_out(po0), .pin_oe(oe0)
   );

   mmio_gpio_ctrl #(.WIDTH(W), .ADDR_W(AW), .DIR_IS_INPUT(1'b1), .BIT_MIRROR(1'b1),
                    .BYTE_SWAP(1'b1), .SET_READBACK(1'b1)) u_alt (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd1), .pin_in(pin_in), .pin_out(po1), .pin_oe(oe1)
   );

   // reference model state, index 0 = default config, 1 = alternate config
   logic [W-1:0] m_out [2];
   logic [W-1:0] m_dir [2];
   logic [W-1:0] m_rd  [2];
   logic [W-1:0] m_s1, m_s2;
   bit           c_pol [2] = '{1'b0, 1'b1};
   bit           c_mir [2] = '{1'b0, 1'b1};
   bit           c_swp [2] = '{1'b0, 1'b1};
   bit           c_rbk [2] = '{1'b0, 1'b1};

   function automatic logic [W-1:0] xf(input logic [W-1:0] w, input bit mir, input bit swp);
      logic [W-1:0] t, u;
      t = w;
      if (swp) for (int b = 0; b < W/8; b++) t[b*8 +: 8] = w[(W/8-1-b)*8 +: 8];
      u = t;
      if (mir) for (int i = 0; i < W; i++) u[i] = t[W-1-i];
      return u;
   endfunction

   function automatic logic [W-1:0] m_oe(input int c);
      return c_pol[c] ? ~m_dir[c] : m_dir[c];
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_out[c] = '0;
         m_dir[c] = c_pol[c] ? '1 : '0;
         m_rd[c]  = '0;
      end
      m_s1 = '0;
      m_s2 = '0;
   endtask

   task automatic model_edge();
      int  idx;
      bit  ok;
      logic [W-1:0] ww, lv, rv;
      ok  = (addr[1:0] == 2'b00) && (addr < 8'd16);
      idx = int'(addr >> 2);
      for (int c = 0; c < 2; c++) begin
         if (rd_en) begin
            rv = '0;
            if (ok) begin
               lv = (m_out[c] & m_oe(c)) | (m_s2 & ~m_oe(c));
               case (idx)
                  0: rv = lv;
                  1: rv = c_rbk[c] ? m_out[c] : '0;
                  3: rv = m_dir[c];
                  default: rv = '0;
               endcase
            end
            m_rd[c] = xf(rv, c_mir[c], c_swp[c]);
         end
         if (wr_en && ok) begin
            ww = xf(wr_data, c_mir[c], c_swp[c]);
            case (idx)
               0: m_out[c] = ww;
               1: m_out[c] = m_out[c] | ww;
               2: m_out[c] = m_out[c] & ~ww;
               default: m_dir[c] = ww;
            endcase
         end
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
   endtask

   task automatic cmp(input string tag, input string fld, input int c,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s dut%0d %s actual=%h expected=%h", tag, c, fld, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      string t1;
      t1 = {tag, " R7+R8"};
      cmp(tag, "rd_data", 0, rd0, m_rd[0]);
      cmp(tag, "pin_out", 0, po0, m_out[0]);
      cmp(tag, "pin_oe",  0, oe0, m_oe(0));
      cmp(t1,  "rd_data", 1, rd1, m_rd[1]);
      cmp(t1,  "pin_out", 1, po1, m_out[1]);
      cmp(t1,  "pin_oe",  1, oe1, m_oe(1));
   endtask

   // drive at falling edge, model at rising edge, compare at next falling edge
   task automatic step(input string tag, input bit we, input bit re,
                       input logic [AW-1:0] a, input logic [W-1:0] d,
                       input logic [W-1:0] pins);
      wr_en = we; rd_en = re; addr = a; wr_data = d; pin_in = pins;
      @(posedge clk);
      if (rst) model_reset(); else model_edge();
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      logic [W-1:0] pins;
      model_reset();
      @(negedge clk);
      step("R10", 0, 0, 0, 0, 32'hFFFF_FFFF);
      step("R10", 0, 0, 0, 0, 32'hFFFF_FFFF);
      rst = 1'b0;
      pins = 32'h1234_8765;
      step("R10", 0, 1, 8'h00, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      // direction polarity
      step("R5",  1, 0, 8'h0C, 32'h0000_FFFF, pins);
      step("R5",  0, 1, 8'h0C, 0, pins);
      // whole-word load, set, clear
      step("R2",  1, 0, 8'h00, 32'hA5A5_5A5A, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      step("R3",  1, 0, 8'h04, 32'h0F00_0001, pins);
      step("R9",  0, 1, 8'h04, 0, pins);
      step("R4",  1, 0, 8'h08, 32'h0000_00F0, pins);
      step("R1",  0, 1, 8'h08, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      // input change through the synchronizer
      pins = 32'hCAFE_0F0F;
      step("R6",  0, 1, 8'h00, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      step("R6",  0, 1, 8'h00, 0, pins);
      // unmapped and misaligned accesses
      step("R1",  0, 1, 8'h10, 0, pins);
      step("R1",  0, 1, 8'h01, 0, pins);
      step("R1",  1, 0, 8'h14, 32'hFFFF_FFFF, pins);
      step("R1",  1, 0, 8'h02, 32'hFFFF_FFFF, pins);
      step("R1",  0, 1, 8'h00, 0, pins);
      // read data holds
      step("R11", 0, 0, 8'h0C, 0, pins);
      step("R11", 1, 0, 8'h00, 32'h0, pins);
      step("R11", 0, 0, 8'h00, 0, pins);
      // all pins driven in each config
      step("R5",  1, 0, 8'h0C, 32'hFFFF_FFFF, pins);
      step("R2",  1, 1, 8'h00, 32'h0102_0304, pins);
      step("R2",  0, 1, 8'h00, 0, pins);
      step("R9",  0, 1, 8'h04, 0, pins);
      // mixed traffic
      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] a;
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
         case (lf[2:0])
            3'd0, 3'd6: a = 8'h00;
            3'd1:       a = 8'h04;
            3'd2:       a = 8'h08;
            3'd3, 3'd7: a = 8'h0C;
            3'd4:       a = 8'h10;
            default:    a = 8'h05;
         endcase
         if (lf[9:8] == 2'b00) pins = {lf[15:0], lf[31:16]};
         step("R2 R3 R4 R6", lf[4], lf[5], a, {lf[7:0], lf[31:8]}, pins);
      end
      // reset mid-run
      rst = 1'b1;
      step("R10", 0, 0, 0, 0, pins);
      rst = 1'b0;
      step("R10", 0, 1, 8'h0C, 0, pins);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule